// File: doc/BRIEF.md
# Warm-Reboot Command Sequencer

This block is a small hardware state machine that tells the device's 32-bit internal configuration port to reload itself from one of several images held in parallel flash. A one-cycle trigger pulse latches an image slot number. The slot number is turned into a flash start address through a table that is fixed when the design is elaborated. The block then plays out a fixed nine-word command script, one word per clock. The script opens with padding and a synchronization word. It then loads the start address into the port's warm-boot address register and ends with the reprogram command, followed by two no-ops.

Each script word leaves the block with the bit order reversed inside every byte, which is the order the configuration port expects. The port's chip-enable and write strobes are plain active-low outputs. After the last word the machine parks in a finished state. Only a synchronous reset returns it to idle.

States and transitions: `ST_IDLE` goes to `ST_SEND` when `trig_i` is seen. `ST_SEND` steps its word index each cycle and goes to `ST_DONE` after the ninth word. `ST_DONE` holds. Any state goes to `ST_IDLE` when `rst` is sampled high.

Top module: `warmboot_seq`

## Requirements
- R1: While in reset and in idle, `cfg_ce_n`=1, `cfg_wr_n`=1, `busy`=0, `done`=0 and `cfg_data`=0.
- R2: A `trig_i` sampled high in idle starts the script on the next cycle. The script lasts exactly 9 consecutive cycles with `cfg_ce_n`=0, `cfg_wr_n`=0 and `busy`=1.
- R3: Before the per-byte bit reversal, the words in order are FFFFFFFF, AA995566 (sync), 20000000, 30020001, the start address, 30008001, 0000000F (reprogram), 20000000, 20000000 (all hex).
- R4: The start address (fifth word) is the table entry for the `slot_sel` value sampled together with the trigger. Changes on `slot_sel` during the script have no effect on it.
- R5: Every emitted word has bit 8b+i of `cfg_data` equal to bit 8b+7-i of the script word, for byte b in 0..3 and bit i in 0..7.
- R6: A `trig_i` pulse while the script runs is ignored. The script keeps its length and its words.
- R7: After the ninth word the block sits in a finished state with `done`=1, `busy`=0, `cfg_ce_n`=1 and `cfg_wr_n`=1. It stays there for any number of cycles and ignores further triggers.
- R8: `rst` sampled high returns the block to idle from any state, including the middle of a script. A later trigger then runs a complete script.
- R9: Eight slots are selectable through a 3-bit `slot_sel`. With the default table, slot k maps to address k x 00800000 hex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Start pulse, honoured only in idle |
| slot_sel | input | 3 | Image slot number, sampled with the trigger |
| cfg_data | output | 32 | Word to the configuration port, bits reversed per byte |
| cfg_ce_n | output | 1 | Port enable, active low, low only while a word is valid |
| cfg_wr_n | output | 1 | Port write strobe, active low, low for the whole script |
| busy | output | 1 | High while the script is being sent |
| done | output | 1 | High once the script has finished, until reset |

## Verification
The script is run once for each of the eight slots. Because only the address word depends on the slot, a wrong table entry or a wrong slot decode shows up in that word alone. The fixed words show whether the byte-wise reversal is applied correctly. A run that toggles `slot_sel` and pulses `trig_i` in the middle of the script separates a correct latch at trigger time from sampling the slot later or restarting. A run that pulses the trigger repeatedly after completion, and a reset in the middle of a script, check the finished state and the return to idle.

// File: rtl/warmboot_pkg.sv
package warmboot_pkg;

    localparam int WORD_W     = 32;
    localparam int SCRIPT_LEN = 9;
    localparam int IDX_W      = $clog2(SCRIPT_LEN);
    localparam int ADDR_POS   = 4;

    localparam logic [WORD_W-1:0] W_PAD      = 32'hFFFF_FFFF;
    localparam logic [WORD_W-1:0] W_SYNC     = 32'hAA99_5566;
    localparam logic [WORD_W-1:0] W_NOOP     = 32'h2000_0000;
    localparam logic [WORD_W-1:0] W_WR_START = 32'h3002_0001;
    localparam logic [WORD_W-1:0] W_WR_CMD   = 32'h3000_8001;
    localparam logic [WORD_W-1:0] W_REPROG   = 32'h0000_000F;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/wb_slot_map.sv
module wb_slot_map #(
    parameter int NUM_SLOTS = 8,
    parameter int ADDR_W    = 32,
    parameter int SEL_W     = 3,
    parameter logic [NUM_SLOTS*ADDR_W-1:0] TABLE = '0
) (
    input  logic [SEL_W-1:0]  sel,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] entry [NUM_SLOTS];

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_entry
        assign entry[k] = TABLE[k*ADDR_W +: ADDR_W];
    end

    always_comb begin
        addr = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (int'(sel) == k) addr = entry[k];
        end
    end
endmodule

// File: rtl/wb_script_rom.sv
module wb_script_rom
    import warmboot_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] start_addr,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        unique case (idx)
            4'd0:    word = W_PAD;
            4'd1:    word = W_SYNC;
            4'd2:    word = W_NOOP;
            4'd3:    word = W_WR_START;
            4'd4:    word = start_addr;
            4'd5:    word = W_WR_CMD;
            4'd6:    word = W_REPROG;
            4'd7:    word = W_NOOP;
            4'd8:    word = W_NOOP;
            default: word = W_NOOP;
        endcase
    end
endmodule

// File: rtl/wb_byte_swap.sv
module wb_byte_swap #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int NBYTES = DATA_W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign dout[8*b + i] = din[8*b + 7 - i];
        end
    end
endmodule

// File: rtl/warmboot_seq.sv
module warmboot_seq
    import warmboot_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter logic [NUM_SLOTS*WORD_W-1:0] SLOT_TABLE = {
        32'h0380_0000, 32'h0300_0000, 32'h0280_0000, 32'h0200_0000,
        32'h0180_0000, 32'h0100_0000, 32'h0080_0000, 32'h0000_0000
    },
    localparam int SEL_W = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic [SEL_W-1:0]  slot_sel,
    output logic [WORD_W-1:0] cfg_data,
    output logic              cfg_ce_n,
    output logic              cfg_wr_n,
    output logic              busy,
    output logic              done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SCRIPT_LEN - 1);

    seq_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [SEL_W-1:0]  slot_q;
    logic [WORD_W-1:0] start_addr;
    logic [WORD_W-1:0] raw_word;
    logic [WORD_W-1:0] swapped;

    wb_slot_map #(
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (WORD_W),
        .SEL_W     (SEL_W),
        .TABLE     (SLOT_TABLE)
    ) u_map (
        .sel  (slot_q),
        .addr (start_addr)
    );

    wb_script_rom u_rom (
        .idx        (idx),
        .start_addr (start_addr),
        .word       (raw_word)
    );

    wb_byte_swap #(.DATA_W(WORD_W)) u_swap (
        .din  (raw_word),
        .dout (swapped)
    );

    // State register and sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            slot_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (trig_i) begin
                        slot_q <= slot_sel;
                        idx    <= '0;
                        state  <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (idx == LAST_IDX) begin
                        state <= ST_DONE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_DONE: begin
                    state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode
    always_comb begin
        cfg_data = '0;
        cfg_ce_n = 1'b1;
        cfg_wr_n = 1'b1;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SEND: begin
                cfg_data = swapped;
                cfg_ce_n = 1'b0;
                cfg_wr_n = 1'b0;
                busy     = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/wb_seq_checker.sv
module wb_seq_checker #(
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             trig_i,
    input logic [31:0]      cfg_data,
    input logic             cfg_ce_n,
    input logic             cfg_wr_n,
    input logic             busy,
    input logic             done,
    input logic [SEL_W-1:0] slot_q
);
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy) |-> (cfg_ce_n && cfg_wr_n));

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && trig_i) |=> (busy && !cfg_ce_n && !cfg_wr_n));

    // Pad word FFFFFFFF reversed per byte is unchanged
    p_first_word_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (cfg_data == 32'hFFFF_FFFF));

    p_slot_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(slot_q));

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && !busy && cfg_ce_n));

    p_end_to_done_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |-> done);
endmodule

bind warmboot_seq wb_seq_checker #(.SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .trig_i   (trig_i),
    .cfg_data (cfg_data),
    .cfg_ce_n (cfg_ce_n),
    .cfg_wr_n (cfg_wr_n),
    .busy     (busy),
    .done     (done),
    .slot_q   (slot_q)
);

// File: tb/warmboot_seq_bench.sv
`timescale 1ns/1ps
module warmboot_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig_i = 1'b0;
    logic [2:0]  slot_sel = 3'd0;
    logic [31:0] cfg_data;
    logic        cfg_ce_n, cfg_wr_n, busy, done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    warmboot_seq u_warmboot_seq (
        .clk      (clk),
        .rst      (rst),
        .trig_i   (trig_i),
        .slot_sel (slot_sel),
        .cfg_data (cfg_data),
        .cfg_ce_n (cfg_ce_n),
        .cfg_wr_n (cfg_wr_n),
        .busy     (busy),
        .done     (done)
    );

    function automatic logic [31:0] rev_bytes(input logic [31:0] w);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = w[(i/8)*8 + 7 - (i%8)];
        return r;
    endfunction

    // R3/R9 expected script word
    function automatic logic [31:0] script_word(input int n, input int slot);
        case (n)
            0: return 32'hFFFF_FFFF;
            1: return 32'hAA99_5566;
            3: return 32'h3002_0001;
            4: return 32'(slot) * 32'h0080_0000;
            5: return 32'h3000_8001;
            6: return 32'h0000_000F;
            default: return 32'h2000_0000;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_quiet(input string req, input logic exp_done);
        check(req, {cfg_ce_n, cfg_wr_n, busy, done}, {1'b1, 1'b1, 1'b0, exp_done});
    endtask

    // Run a script; optionally disturb it with slot changes and triggers mid-run
    task automatic run_slot(input int slot, input bit disturb);
        slot_sel = 3'(slot);
        trig_i   = 1'b1;
        tick();
        trig_i = 1'b0;
        for (int n = 0; n < 9; n++) begin
            check("R2 strobes", {cfg_ce_n, cfg_wr_n, busy, done}, 4'b0010);
            check("R3/R4/R5 word", cfg_data, rev_bytes(script_word(n, slot)));
            if (disturb) begin
                slot_sel = 3'(slot ^ 7);
                trig_i   = (n % 2 == 0);   // R6 stray triggers
            end
            tick();
        end
        trig_i = 1'b0;
        check_quiet("R7 finished", 1'b1);
    endtask

    initial begin
        rst = 1'b1;
        tick();
        check_quiet("R1 reset", 1'b0);
        check("R1 data", cfg_data, 32'h0);
        tick();
        rst = 1'b0;
        tick();
        check_quiet("R1 idle", 1'b0);

        // R9 sweep over all slots
        for (int s = 0; s < 8; s++) begin
            rst = 1'b1; tick(); rst = 1'b0; tick();
            run_slot(s, 1'b0);
        end

        // R4 and R6: slot changes and triggers during the script
        rst = 1'b1; tick(); rst = 1'b0; tick();
        run_slot(5, 1'b1);

        // R7: stays finished and ignores triggers
        for (int k = 0; k < 6; k++) begin
            trig_i = (k % 2 == 0);
            tick();
            check_quiet("R7 hold", 1'b1);
            check("R7 data", cfg_data, 32'h0);
        end
        trig_i = 1'b0;

        // R8: reset in the middle of a script, then a full run
        rst = 1'b1; tick(); rst = 1'b0; tick();
        slot_sel = 3'd3; trig_i = 1'b1; tick(); trig_i = 1'b0;
        tick(); tick(); tick();
        check("R8 mid-run busy", busy, 1'b1);
        rst = 1'b1; tick(); rst = 1'b0;
        check_quiet("R8 back to idle", 1'b0);
        tick(); tick();
        check_quiet("R8 idle stays", 1'b0);
        run_slot(6, 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule